// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block is a small peripheral that sits on an 8-bit processor bus and offers three 8-bit parallel ports, called A, B and C, plus one control register that can only be written. The bus side uses an active-low chip select, a two-bit address and active-low read and write strobes. At run time, a configuration word written to the control register picks the direction of port A, port B and each half of port C. A second command format, written to the same address, forces a single bit of port C high or low and leaves its other bits alone.

Each port pin is modelled as three vectors: the live input level, the value of the output latch, and an output enable. The surrounding pad logic turns these into real pins. Every port runs as plain unhandshaked I/O. When a port or half-port is set as an input, its enable is low and a read returns the pins. When it is set as an output, its enable is high and a read returns its latch.

The bus strobes are sampled on the block clock. A write takes effect at the first clock edge on which the chip select and the write strobe are both seen low. Reads are combinational while the chip select and the read strobe are low.

Top module: `ppio_core`

## Requirements
- R1: While `rst` is high, and after it is released, all three output enables are 0 (every port is an input) and every output latch is 0x00.
- R2: When `cs_n` is low, `addr` selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. When `cs_n` is high, writes are ignored and `rdata` is 0x00.
- R3: A control write with bit 7 = 1 is a configuration word. Bit 4 = 1 makes port A an input, bit 1 = 1 makes port B an input, bit 3 = 1 makes port C bits 7..4 an input, and bit 0 = 1 makes port C bits 3..0 an input. A 0 in any of these bits makes that group an output, and the group's enable bits follow on the next cycle. For example, 0x90 gives A input, B output and all of C output.
- R4: Every configuration word clears the A, B and C output latches to 0x00.
- R5: A control write with bit 7 = 0 is a bit command. Bits 3..1 hold the index of a port C bit and bit 0 holds the value written to that bit. All other port C latch bits keep their values, and the direction of every port is left unchanged.
- R6: A read of port A or port B returns the pins when that port is an input and its latch when it is an output. A read of port C builds each nibble separately in the same way, from that nibble's own direction.
- R7: A read of the control address returns 0x00. A write to a port that is set as an input still loads its latch, and that latch shows on the port's output vector.
- R8: Holding the write strobe low for several cycles commits only one write, using the data present on the first active cycle. Changing `wdata` while the strobe stays low has no effect.
- R9: A committed write appears on the port outputs exactly one cycle after the cycle in which the strobe is first seen active. The outputs do not change in any cycle that has no commit.
- R10: Bits 6, 5 and 2 of a configuration word have no effect. A word that differs from another only in those bits gives the same directions and the same cleared latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data to the bus |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
A corrupted direction bit shows up on the matching enable vector and in the read-back source in the very cycle after the bad commit, so the per-clock comparison catches it at once. A wrong latch value is visible on the output vectors straight away, not only when it is read back, and a wrong bit command also disturbs a neighbouring bit of port C. A fault in the strobe edge detection shows up as a second commit while the strobe is held low: the data changes one clock later, while the reference model keeps the first value.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    localparam int DW   = 8;
    localparam int HALF = DW / 2;
    localparam int IXW  = $clog2(DW);

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    // 1 = group is an input
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cu_in;
        logic cl_in;
    } dir_t;

    localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};

    typedef struct packed {
        logic           is_cfg;
        dir_t           dir;
        logic [IXW-1:0] bit_idx;
        logic           bit_val;
    } ctl_cmd_t;

    typedef struct packed {
        logic          we_a;
        logic          we_b;
        logic          we_c;
        logic          we_ctl;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic ctl_cmd_t decode_ctl(input logic [DW-1:0] w);
        ctl_cmd_t c;
        c.is_cfg     = w[7];
        c.dir.a_in   = w[4];
        c.dir.cu_in  = w[3];
        c.dir.b_in   = w[1];
        c.dir.cl_in  = w[0];
        c.bit_idx    = w[IXW:1];
        c.bit_val    = w[0];
        return c;
    endfunction

    function automatic logic [DW-1:0] pick_byte(input logic [DW-1:0] pins,
                                                input logic [DW-1:0] lat,
                                                input logic          is_in);
        return is_in ? pins : lat;
    endfunction

endpackage

// File: rtl/ppio_bus_fe.sv
module ppio_bus_fe
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_go,
    output wr_req_t       req
);
    logic act, act_q;

    assign act = ~cs_n & ~wr_n;

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= act;
    end

    assign wr_go = act & ~act_q;

    always_comb begin
        req        = '0;
        req.data   = wdata;
        if (wr_go) begin
            unique case (sel_e'(addr))
                SEL_A:    req.we_a   = 1'b1;
                SEL_B:    req.we_b   = 1'b1;
                SEL_C:    req.we_c   = 1'b1;
                SEL_CTRL: req.we_ctl = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ppio_ctl_reg.sv
module ppio_ctl_reg
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] data,
    output dir_t          dir,
    output logic          clr_all,
    output logic [DW-1:0] bit_mask,
    output logic          bit_val
);
    ctl_cmd_t cmd;

    assign cmd      = decode_ctl(data);
    assign clr_all  = we & cmd.is_cfg;
    assign bit_mask = (we & ~cmd.is_cfg) ? (DW'(1) << cmd.bit_idx) : '0;
    assign bit_val  = cmd.bit_val;

    always_ff @(posedge clk) begin
        if (rst)          dir <= DIR_RESET;
        else if (clr_all) dir <= cmd.dir;
    end
endmodule

// File: rtl/ppio_latch.sv
module ppio_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] bit_mask,
    input  logic         bit_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (clr) q <= '0;
        else if (we)  q <= wdata;
        else          q <= (q & ~bit_mask) | (bit_mask & {W{bit_val}});
    end
endmodule

// File: rtl/ppio_core.sv
module ppio_core
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    wr_req_t       req;
    logic          wr_go;
    dir_t          dir;
    logic          clr_all;
    logic [DW-1:0] bit_mask;
    logic          bit_val;
    logic [DW-1:0] pc_rd;

    ppio_bus_fe u_fe (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .wr_go(wr_go), .req(req)
    );

    ppio_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .we(req.we_ctl), .data(req.data),
        .dir(dir), .clr_all(clr_all), .bit_mask(bit_mask), .bit_val(bit_val)
    );

    ppio_latch #(.W(DW)) u_lat_a (
        .clk(clk), .rst(rst), .clr(clr_all), .we(req.we_a), .wdata(req.data),
        .bit_mask('0), .bit_val(1'b0), .q(pa_out)
    );

    ppio_latch #(.W(DW)) u_lat_b (
        .clk(clk), .rst(rst), .clr(clr_all), .we(req.we_b), .wdata(req.data),
        .bit_mask('0), .bit_val(1'b0), .q(pb_out)
    );

    // port C: two independently directed halves
    for (genvar h = 0; h < 2; h++) begin : g_chalf
        logic half_in;
        assign half_in = (h == 1) ? dir.cu_in : dir.cl_in;

        ppio_latch #(.W(HALF)) u_lat_c (
            .clk(clk), .rst(rst), .clr(clr_all), .we(req.we_c),
            .wdata(req.data[h*HALF +: HALF]),
            .bit_mask(bit_mask[h*HALF +: HALF]), .bit_val(bit_val),
            .q(pc_out[h*HALF +: HALF])
        );

        assign pc_oe[h*HALF +: HALF] = {HALF{~half_in}};
        assign pc_rd[h*HALF +: HALF] = half_in ? pc_in[h*HALF +: HALF]
                                               : pc_out[h*HALF +: HALF];
    end

    assign pa_oe = {DW{~dir.a_in}};
    assign pb_oe = {DW{~dir.b_in}};

    always_comb begin
        rdata = '0;
        if (!cs_n && !rd_n) begin
            unique case (sel_e'(addr))
                SEL_A:    rdata = pick_byte(pa_in, pa_out, dir.a_in);
                SEL_B:    rdata = pick_byte(pb_in, pb_out, dir.b_in);
                SEL_C:    rdata = pc_rd;
                SEL_CTRL: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ppio_chk.sv
module ppio_chk
    import ppio_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic [1:0]    addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic [DW-1:0] pa_out,
    input logic [DW-1:0] pa_oe,
    input logic [DW-1:0] pb_out,
    input logic [DW-1:0] pb_oe,
    input logic [DW-1:0] pc_out,
    input logic [DW-1:0] pc_oe,
    input logic          wr_go
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                        pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R2
    deselect_read_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> rdata == '0);

    // R3
    cfg_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && addr == 2'd3 && wdata[7]) |=>
            (pa_oe == {DW{~$past(wdata[4])}} && pb_oe == {DW{~$past(wdata[1])}} &&
             pc_oe == {{HALF{~$past(wdata[3])}}, {HALF{~$past(wdata[0])}}}));

    // R4
    cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && addr == 2'd3 && wdata[7]) |=>
            (pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R5
    bit_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && addr == 2'd3 && !wdata[7]) |=>
            (pc_out[$past(wdata[3:1])] == $past(wdata[0]) &&
             ((pc_out ^ $past(pc_out)) & ~(DW'(1) << $past(wdata[3:1]))) == '0 &&
             $stable(pc_oe) && $stable(pa_oe) && $stable(pb_oe)));

    // R9
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_go |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                    $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

bind ppio_core ppio_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out),
    .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe), .wr_go(wr_go)
);

// File: tb/ppio_core_test.sv
`timescale 1ns/1ps
module ppio_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    ppio_core uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // reference model state
    logic [7:0] m_a, m_b, m_c;
    bit d_a, d_b, d_cu, d_cl;   // 1 = input
    bit m_prev;

    always @(posedge clk) begin
        bit strobe;
        strobe = !cs_n && !wr_n;
        if (rst) begin
            m_a = 0; m_b = 0; m_c = 0;
            d_a = 1; d_b = 1; d_cu = 1; d_cl = 1;
            m_prev = 0;
        end else begin
            if (strobe && !m_prev) begin
                case (addr)
                    2'd0: m_a = wdata;
                    2'd1: m_b = wdata;
                    2'd2: m_c = wdata;
                    default: begin
                        if (wdata[7]) begin
                            d_a = wdata[4]; d_cu = wdata[3];
                            d_b = wdata[1]; d_cl = wdata[0];
                            m_a = 0; m_b = 0; m_c = 0;
                        end else begin
                            m_c[wdata[3:1]] = wdata[0];
                        end
                    end
                endcase
            end
            m_prev = strobe;
        end
    end

    function automatic logic [7:0] exp_rd();
        logic [7:0] r;
        r = 8'h00;
        if (!cs_n && !rd_n) begin
            case (addr)
                2'd0: r = d_a ? pa_in : m_a;
                2'd1: r = d_b ? pb_in : m_b;
                2'd2: r = {d_cu ? pc_in[7:4] : m_c[7:4], d_cl ? pc_in[3:0] : m_c[3:0]};
                default: r = 8'h00;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (cmp_on && !done) begin
            chk("R3 pa_oe", pa_oe, {8{~d_a}});
            chk("R3 pb_oe", pb_oe, {8{~d_b}});
            chk("R3 pc_oe", pc_oe, {{4{~d_cu}}, {4{~d_cl}}});
            chk("R9 pa_out", pa_out, m_a);
            chk("R9 pb_out", pb_out, m_b);
            chk("R9 pc_out", pc_out, m_c);
            chk("R6 rdata", rdata, exp_rd());
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 0; wr_n = 0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
        #3;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 0; rd_n = 0; addr = a;
        #3 d = rdata;
        @(negedge clk);
        cs_n = 1; rd_n = 1;
        #3;
    endtask

    initial begin
        logic [7:0] rv;
        logic [7:0] sav_oe_b, sav_oe_c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cmp_on = 1;
        #3;
        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 pb_out", pb_out, 8'h00);
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
        bus_read(2'd1, rv);
        chk("R1 read B pins", rv, 8'hC3);

        // R3 0x90
        bus_write(2'd3, 8'h90);
        chk("R3 A input", pa_oe, 8'h00);
        chk("R3 B output", pb_oe, 8'hFF);
        chk("R3 C output", pc_oe, 8'hFF);

        bus_write(2'd1, 8'hA5);
        bus_write(2'd2, 8'h3C);
        bus_read(2'd1, rv);
        chk("R6 read B latch", rv, 8'hA5);
        bus_read(2'd0, rv);
        chk("R6 read A pins", rv, 8'h5A);
        bus_read(2'd2, rv);
        chk("R2 read C latch", rv, 8'h3C);

        // R5 bit commands
        bus_write(2'd3, 8'h0F);            // bit 7 <- 1
        chk("R5 set bit7", pc_out, 8'hBC);
        bus_write(2'd3, 8'h04);            // bit 2 <- 0
        chk("R5 clear bit2", pc_out, 8'hB8);
        bus_write(2'd3, 8'h01);            // bit 0 <- 1
        chk("R5 set bit0", pc_out, 8'hB9);
        chk("R5 dirs kept", pc_oe, 8'hFF);

        // R4 / R6 mixed halves
        bus_write(2'd3, 8'h81);
        chk("R4 C cleared", pc_out, 8'h00);
        chk("R4 B cleared", pb_out, 8'h00);
        chk("R3 C split oe", pc_oe, 8'hF0);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, rv);
        chk("R6 C mixed read", rv, 8'hF6);

        // R10 ignored group-mode bits
        bus_write(2'd1, 8'h77);
        bus_write(2'd3, 8'hE4);
        chk("R10 A oe", pa_oe, 8'hFF);
        chk("R10 C oe", pc_oe, 8'hFF);
        chk("R10 B cleared", pb_out, 8'h00);

        // R2 deselected write and read
        @(negedge clk);
        cs_n = 1; wr_n = 0; addr = 2'd1; wdata = 8'h3E;
        @(negedge clk);
        wr_n = 1;
        #3 chk("R2 no write deselected", pb_out, 8'h00);
        rd_n = 0; addr = 2'd1;
        #1 chk("R2 deselected read", rdata, 8'h00);
        rd_n = 1;

        // R7 control read and write to input port
        bus_read(2'd3, rv);
        chk("R7 ctrl read", rv, 8'h00);
        bus_write(2'd3, 8'h92);            // A, B inputs
        bus_write(2'd0, 8'h4D);
        chk("R7 latch on input port", pa_out, 8'h4D);
        bus_read(2'd0, rv);
        chk("R7 read input pins", rv, 8'h5A);

        // R8 / R9 held strobe
        sav_oe_b = pb_oe; sav_oe_c = pc_oe;
        @(negedge clk);
        cs_n = 0; wr_n = 0; addr = 2'd2; wdata = 8'h11;
        #3 chk("R9 no early change", pc_out, 8'h00);
        @(negedge clk);
        #3 chk("R9 one cycle latency", pc_out, 8'h11);
        wdata = 8'h22;
        repeat (3) @(negedge clk);
        #3 chk("R8 single commit", pc_out, 8'h11);
        chk("R8 oe unchanged", pb_oe, sav_oe_b);
        @(negedge clk);
        cs_n = 1; wr_n = 1;
        repeat (2) @(negedge clk);
        #3 chk("R9 held", pc_out, 8'h11);
        chk("R9 oe held", pc_oe, sav_oe_c);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R9 watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule